// File: doc/BRIEF.md
# SMM Memory Window Remap Decoder

This block holds the one-byte control setting for system-management memory and turns it into at most one active remap window. Software loads the control byte through a simple write port. On every lookup the block compares the incoming host address against the active window. It reports whether the access hits that window and gives the physical address to use. It also raises a marking flag that tells the memory map the range carries an extra access state.

Three fixed windows exist, chosen by a two-bit select field. Two of them are 64 KB host ranges, one at 0xD0000 and one at 0x30000, and both land at physical 0xB0000. The third is a 128 KB legacy range at 0xA0000 that maps onto itself. A master enable bit gates all of them. A visibility bit decides whether accesses made outside system-management mode may use the window. The control byte sits in a register. The hit, address and marking outputs are combinational from that register and the lookup inputs.

Top module: `smwin_decoder`

## Requirements
- R1: After reset the control byte reads 0x00, no address hits, and the marking output is low.
- R2: A write stores only bits 4:0 of the written byte, and bits 7:5 read back as zero. The new value takes effect at the clock edge that captures the write, so a lookup in the same cycle as the write still uses the old value.
- R3: While bit 0 (enable) is clear, no address hits and the marking output stays low, whatever bits 4:1 hold.
- R4: Select code 00 in bits 3:2 makes host 0xD0000 to 0xDFFFF active, and the address becomes 0xB0000 plus the offset from 0xD0000.
- R5: Select code 01 makes host 0xA0000 to 0xBFFFF active, and the address is passed through unchanged.
- R6: Select code 10 makes host 0x30000 to 0x3FFFF active, and the address becomes 0xB0000 plus the offset from 0x30000.
- R7: Select code 11 activates no window, even with the enable bit set.
- R8: An address inside the active window hits only if the access is in system-management mode or bit 1 (visible) is set. Otherwise hit is low and the address passes through unchanged.
- R9: An address outside the active window gives hit low and leaves the address unchanged.
- R10: The marking output is high exactly when the address is inside the active window and bit 4 is set, whatever the mode of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write strobe for the control byte |
| cfg_wdata | input | 8 | Control byte to write |
| cfg_rdata | output | 8 | Stored control byte |
| acc_addr | input | ADDR_W | Host address of the access |
| acc_smm | input | 1 | Access made in system-management mode |
| win_hit | output | 1 | Access hits the active window |
| xlat_addr | output | ADDR_W | Translated or passed-through address |
| win_mark | output | 1 | Address lies in a marked active window |

## Verification
A control write and an address lookup can fall in the same cycle. The lookup must then use the stored value from before the write. The bench sets a new select code and an address inside the new window during the same low clock phase. It first checks that the outputs still follow the old setting, and after the capturing edge it checks that they follow the new one. The bench also changes the mode bit and the address within one cycle, so that visibility and marking are judged on the same lookup.

// File: rtl/smwin_pkg.sv
package smwin_pkg;

    localparam int CFG_W    = 8;
    localparam int NUM_WIN  = 3;
    localparam logic [CFG_W-1:0] KEEP_MASK = 8'h1F;

    typedef enum logic [1:0] {
        SEL_HIGH_D   = 2'b00,
        SEL_LEGACY_A = 2'b01,
        SEL_LOW_3    = 2'b10,
        SEL_NONE     = 2'b11
    } win_sel_e;

    // bit 4 mark, bits 3:2 select, bit 1 visible, bit 0 enable
    typedef struct packed {
        logic     mark;
        win_sel_e sel;
        logic     visible;
        logic     enable;
    } ctl_t;

    function automatic logic [31:0] win_host_base(input int idx);
        case (idx)
            0:       return 32'h000D_0000;
            1:       return 32'h000A_0000;
            default: return 32'h0003_0000;
        endcase
    endfunction

    function automatic logic [31:0] win_phys_base(input int idx);
        case (idx)
            0:       return 32'h000B_0000;
            1:       return 32'h000A_0000;
            default: return 32'h000B_0000;
        endcase
    endfunction

    function automatic logic [31:0] win_span(input int idx);
        return (idx == 1) ? 32'h0002_0000 : 32'h0001_0000;
    endfunction

endpackage

// File: rtl/smwin_ctl_reg.sv
module smwin_ctl_reg
    import smwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output ctl_t             ctl_o,
    output logic [CFG_W-1:0] rdata_o
);

    typedef struct packed {
        ctl_t ctl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctl = ctl_t'(wr_data[4:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o   = st_q.ctl;
    assign rdata_o = {3'b000, st_q.ctl};

    assert_write_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rdata_o == ($past(wr_data) & KEEP_MASK)));

    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rdata_o));

endmodule

// File: rtl/smwin_window_sel.sv
module smwin_window_sel
    import smwin_pkg::*;
(
    input  ctl_t               ctl_i,
    output logic [NUM_WIN-1:0] act_o
);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_act
        assign act_o[i] = ctl_i.enable && (ctl_i.sel == win_sel_e'(i));
    end

endmodule

// File: rtl/smwin_addr_xlat.sv
module smwin_addr_xlat
    import smwin_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               smm_i,
    input  logic [NUM_WIN-1:0] act_i,
    input  logic               visible_i,
    input  logic               mark_i,
    output logic               hit_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               mark_o
);

    logic [NUM_WIN-1:0] in_win;
    logic [ADDR_W-1:0]  cand [NUM_WIN];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam logic [ADDR_W-1:0] HOST = ADDR_W'(win_host_base(i));
        localparam logic [ADDR_W-1:0] PHYS = ADDR_W'(win_phys_base(i));
        localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(win_span(i));
        logic [ADDR_W-1:0] off;
        assign off       = addr_i - HOST;
        assign in_win[i] = act_i[i] && (addr_i >= HOST) && (off < SPAN);
        assign cand[i]   = PHYS + off;
    end

    logic              any_in;
    logic [ADDR_W-1:0] sel_addr;

    always_comb begin
        any_in   = 1'b0;
        sel_addr = addr_i;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (in_win[i]) begin
                any_in   = 1'b1;
                sel_addr = cand[i];
            end
        end
    end

    assign hit_o  = any_in && (smm_i || visible_i);
    assign addr_o = hit_o ? sel_addr : addr_i;
    assign mark_o = any_in && mark_i;

    assert_single_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_win));

    assert_hidden_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (smm_i || visible_i));

endmodule

// File: rtl/smwin_decoder.sv
module smwin_decoder
    import smwin_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    output logic              win_hit,
    output logic [ADDR_W-1:0] xlat_addr,
    output logic              win_mark
);

    ctl_t               ctl;
    logic [NUM_WIN-1:0] act;

    smwin_ctl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .ctl_o   (ctl),
        .rdata_o (cfg_rdata)
    );

    smwin_window_sel u_sel (
        .ctl_i (ctl),
        .act_o (act)
    );

    smwin_addr_xlat #(.ADDR_W(ADDR_W)) u_xlat (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (acc_addr),
        .smm_i     (acc_smm),
        .act_i     (act),
        .visible_i (ctl.visible),
        .mark_i    (ctl.mark),
        .hit_o     (win_hit),
        .addr_o    (xlat_addr),
        .mark_o    (win_mark)
    );

    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[0] |-> (!win_hit && !win_mark));

    assert_code3_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[3:2] == 2'b11) |-> (!win_hit && !win_mark));

    assert_miss_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> (xlat_addr == acc_addr));

    assert_mark_needs_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        win_mark |-> (cfg_rdata[4] && cfg_rdata[0]));

endmodule

// File: tb/smwin_decoder_test.sv
module smwin_decoder_test;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_smm = 1'b0;
    logic          win_hit;
    logic [AW-1:0] xlat_addr;
    logic          win_mark;

    int total = 0;
    int bad   = 0;
    logic [7:0] cfg_m = 8'h00;

    always #10 clk = ~clk;

    smwin_decoder #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .acc_addr(acc_addr), .acc_smm(acc_smm),
        .win_hit(win_hit), .xlat_addr(xlat_addr), .win_mark(win_mark)
    );

    // Reference model built from the requirements
    function automatic logic [AW+1:0] model(input logic [7:0] c, input logic [AW-1:0] a,
                                            input logic smm);
        logic in; logic [AW-1:0] p; logic h;
        in = 1'b0; p = a;
        if (c[0]) begin
            case (c[3:2])
                2'b00: if (a >= 32'hD0000 && a <= 32'hDFFFF) begin in = 1; p = a - 32'hD0000 + 32'hB0000; end
                2'b01: if (a >= 32'hA0000 && a <= 32'hBFFFF) begin in = 1; p = a; end
                2'b10: if (a >= 32'h30000 && a <= 32'h3FFFF) begin in = 1; p = a - 32'h30000 + 32'hB0000; end
                default: ;
            endcase
        end
        h = in && (smm || c[1]);
        return {h, in && c[4], h ? p : a};
    endfunction

    task automatic chk(input string tag, input logic [AW-1:0] a, input logic smm);
        logic [AW+1:0] e;
        acc_addr = a; acc_smm = smm;
        #1;
        e = model(cfg_m, a, smm);
        total++;
        if ({win_hit, win_mark, xlat_addr} !== e) begin
            bad++;
            $display("FAIL %s addr=%h smm=%0b: got hit=%0b mark=%0b xlat=%h exp hit=%0b mark=%0b xlat=%h",
                     tag, a, smm, win_hit, win_mark, xlat_addr, e[AW+1], e[AW], e[AW-1:0]);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [7:0] exp);
        total++;
        if (cfg_rdata !== exp) begin
            bad++;
            $display("FAIL %s rdata got=%h exp=%h", tag, cfg_rdata, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_m = v & 8'h1F;
    endtask

    task automatic t_reset();
        chk_rd("R1", 8'h00);
        chk("R1", 32'hA0000, 1'b1);
        chk("R1", 32'hD0000, 1'b1);
    endtask

    task automatic t_mask();
        wr(8'hFF);
        chk_rd("R2", 8'h1F);
        wr(8'hE5);
        chk_rd("R2", 8'h05);
    endtask

    task automatic t_disabled();
        wr(8'h12);
        chk("R3", 32'hD0000, 1'b1);
        wr(8'h16);
        chk("R3", 32'hA0000, 1'b1);
    endtask

    task automatic t_code00();
        wr(8'h03);
        chk("R4", 32'hCFFFF, 1'b1);
        chk("R4", 32'hD0000, 1'b1);
        chk("R4", 32'hD1234, 1'b0);
        chk("R4", 32'hDFFFF, 1'b1);
        chk("R4", 32'hE0000, 1'b1);
    endtask

    task automatic t_code01();
        wr(8'h05);
        chk("R5", 32'h9FFFF, 1'b1);
        chk("R5", 32'hA0000, 1'b1);
        chk("R5", 32'hBFFFF, 1'b1);
        chk("R5", 32'hC0000, 1'b1);
    endtask

    task automatic t_code10();
        wr(8'h0B);
        chk("R6", 32'h2FFFF, 1'b1);
        chk("R6", 32'h30000, 1'b0);
        chk("R6", 32'h3ABCD, 1'b1);
        chk("R6", 32'h40000, 1'b1);
    endtask

    task automatic t_code11();
        wr(8'h1F);
        chk("R7", 32'hD0000, 1'b1);
        chk("R7", 32'hA0000, 1'b1);
        chk("R7", 32'h30000, 1'b1);
    endtask

    task automatic t_visibility();
        wr(8'h01);
        chk("R8", 32'hD4000, 1'b0);
        chk("R8", 32'hD4000, 1'b1);
        wr(8'h0B);
        chk("R8", 32'h30010, 1'b0);
    endtask

    task automatic t_outside();
        wr(8'h07);
        chk("R9", 32'h12345678, 1'b1);
        chk("R9", 32'h000A0000 + 32'h100000, 1'b1);
    endtask

    task automatic t_mark();
        wr(8'h11);
        chk("R10", 32'hD8000, 1'b0);
        chk("R10", 32'hE8000, 1'b0);
        wr(8'h15);
        chk("R10", 32'hA1000, 1'b1);
    endtask

    task automatic t_same_cycle();
        wr(8'h03);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'h07;
        chk("R2", 32'hA2000, 1'b1);   // old setting (code 00) still in force
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_m = 8'h07;
        chk("R2", 32'hA2000, 1'b1);   // new setting (code 01)
        chk_rd("R2", 8'h07);
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_disabled();
        t_code00();
        t_code01();
        t_code10();
        t_code11();
        t_visibility();
        t_outside();
        t_mark();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule